// File: doc/BRIEF.md
# AAL5 Cut-Through Reassembly Engine

The engine takes ATM cells from many interleaved virtual connections and rebuilds AAL5 packets without ever storing a whole packet. Each cell enters as 13 consecutive 32-bit words: one header word and twelve payload words. The connection number (VCID) is taken straight from the low bits of the header's VCI field. For every connection, the engine keeps a running byte count and a running CRC-32 between cells.

Each connection's newest cell is held back until the next cell of that connection arrives. It is then released on the packet output, tagged with its VCID. Because of this one-cell delay, pad bytes that spill from the final cell into the one before it can still be removed. When the final cell arrives, the engine checks the CRC residue and the trailer length, strips the pad and trailer, and ends the packet with a status code, the UU byte and the CPI byte.

Each connection also has an inactivity timer, driven by a shared tick input. If the timer runs out, the engine closes the stalled packet with a timeout status.

Top module: `aal5_reasm`

## Requirements
- R1: The output VCID equals the low log2(NUM_VC) bits of the header VCI field (header bits 19:4). The VPI, the GFC and the higher VCI bits have no effect.
- R2: A cell is a header word followed by 12 payload words. A word is accepted when in_valid and in_ready are both high. Header bit 1 set to 1 marks the final cell of a packet. in_ready is low while the engine is forwarding.
- R3: A non-final cell produces no output until the next cell of the same connection has been accepted. That next cell then releases the held 48 bytes as 12 words.
- R4: out_sop is high on the first forwarded word of a packet, and out_eop is high on its last word. out_vcid does not change within a burst, and a burst ending in out_eop is followed by an idle cycle.
- R5: Bytes are packed big-endian, with the first byte in bits 31:24. On a correct packet, exactly the trailer-length number of bytes is forwarded and pad is never forwarded, even when the pad fills the whole final cell. out_bytes gives the number of valid bytes (1 to 4) in the out_eop word and reads 4 on every other word.
- R6: The CRC-32 (polynomial 0x04C11DB7, initial value all ones, MSB first) runs over all 48 payload bytes of every cell, including the CRC field. The packet is correct when the result is 0xC704DD7B; if the result differs and the length is correct, out_status is 1.
- R7: Let N be the number of received bytes and L the trailer length. If N-8-L lies outside 0 to 47, or if L is 0, out_status is 2 and every received byte except the final 8 is forwarded. The limits 0 and 47 themselves are accepted.
- R8: A packet that passes both checks ends with out_status 0. The trailer UU byte (payload byte 40 of the final cell) and CPI byte (byte 41) appear on out_uu and out_cpi with out_eop.
- R9: Once a connection holds a cell and TMO_TICKS tick pulses arrive with no new cell on it, the engine forwards the held 12 words. The burst ends with out_eop, out_bytes 4 and out_status 3, and the connection is closed. Fewer ticks produce nothing.
- R10: Every accepted cell of a connection restarts that connection's timer.
- R11: Packets on different connections may interleave cell by cell, and each connection's data, length and CRC stay separate.
- R12: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Cell word valid |
| in_data | input | 32 | Cell word (header, then payload) |
| in_ready | output | 1 | Engine accepts a word this cycle |
| tick | input | 1 | Timer advance pulse shared by all connections |
| out_valid | output | 1 | Packet word valid |
| out_data | output | 32 | Packet data, big-endian |
| out_vcid | output | log2(NUM_VC) | Connection of the word |
| out_sop | output | 1 | First word of a packet |
| out_eop | output | 1 | Last word of a packet |
| out_bytes | output | 3 | Valid bytes in the word (1 to 4) |
| out_status | output | 2 | 0 good, 1 CRC error, 2 length error, 3 timeout; valid with out_eop |
| out_uu | output | 8 | Trailer UU byte, valid with out_eop |
| out_cpi | output | 8 | Trailer CPI byte, valid with out_eop |

## Verification
The hardest situations to reach are the ones that depend on how far the pad spreads back into the held cell. The first is a packet whose final cell carries only pad and trailer, so every forwarded byte comes from the held cell. The second is a packet whose byte count sits exactly at 0 or 47 past the minimum. The stimulus builds such packets with chosen lengths (40, 41, 44), so the end falls inside the held cell at a known word and byte. Timer expiry is reached by holding one cell and sending a counted number of tick pulses, stopping one short and then adding the last one.

// File: rtl/aal5_reasm.sv
`timescale 1ns/1ps
module aal5_reasm #(
  parameter int NUM_VC     = 4,
  parameter int TMO_TICKS  = 8,
  parameter int CELL_WORDS = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [31:0]               in_data,
  output logic                      in_ready,
  input  logic                      tick,
  output logic                      out_valid,
  output logic [31:0]               out_data,
  output logic [$clog2(NUM_VC)-1:0] out_vcid,
  output logic                      out_sop,
  output logic                      out_eop,
  output logic [2:0]                out_bytes,
  output logic [1:0]                out_status,
  output logic [7:0]                out_uu,
  output logic [7:0]                out_cpi
);
  localparam int VCID_W     = $clog2(NUM_VC);
  localparam int TMR_W      = $clog2(TMO_TICKS + 1);
  localparam int WC_W       = $clog2(CELL_WORDS + 1);
  localparam int IX_W       = $clog2(CELL_WORDS);
  localparam int OK_W       = $clog2(2 * CELL_WORDS + 1);
  localparam int CELL_BYTES = 4 * CELL_WORDS;
  localparam logic [31:0] RESIDUE = 32'hC704DD7B;
  localparam logic [31:0] POLY    = 32'h04C11DB7;
  localparam logic [1:0] M_NORM = 2'd0, M_LAST = 2'd1, M_TMO = 2'd2;

  function automatic logic [31:0] crc_word(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 31; i >= 0; i--)
      r = {r[30:0], 1'b0} ^ ((r[31] ^ d[i]) ? POLY : 32'h0);
    return r;
  endfunction

  logic [31:0]       held    [NUM_VC][CELL_WORDS];
  logic [31:0]       stage   [CELL_WORDS];
  logic [31:0]       crc_mem [NUM_VC];
  logic [15:0]       cnt_mem [NUM_VC];
  logic [TMR_W-1:0]  tmr     [NUM_VC];
  logic [NUM_VC-1:0] held_v, started, exp_v;

  logic              busy;
  logic [WC_W-1:0]   wcnt;
  logic [VCID_W-1:0] cvc, exp_sel, o_vc;
  logic              clast, o_h;
  logic [31:0]       ccrc, o_crc;
  logic [15:0]       ccnt, o_cnt;
  logic [1:0]        o_mode, o_st;
  logic [OK_W-1:0]   o_k, o_nw;
  logic [2:0]        o_lb;
  logic [7:0]        o_uu, o_cpi;

  logic        acc, end_cell, fin, h, lerr, use_held;
  logic [31:0] crc_n;
  logic [17:0] n_tot, len_t, rem_f;
  logic [OK_W-1:0] nw_f;
  logic [2:0]  lb_f;
  logic [IX_W-1:0] rd_ix;

  always_comb begin
    exp_sel = '0;
    for (int v = 0; v < NUM_VC; v++)
      exp_v[v] = held_v[v] && (tmr[v] == TMR_W'(TMO_TICKS));
    for (int v = NUM_VC - 1; v >= 0; v--)
      if (exp_v[v]) exp_sel = VCID_W'(v);
  end

  assign in_ready = !busy && !((wcnt == '0) && (|exp_v));
  assign acc      = in_valid && in_ready;
  assign end_cell = acc && (wcnt == WC_W'(CELL_WORDS));
  assign crc_n    = crc_word(ccrc, in_data);
  assign fin      = busy && (({1'b0, o_k} + 1'b1) >= {1'b0, o_nw});

  assign h     = held_v[cvc];
  assign n_tot = {2'b0, ccnt} + 18'(CELL_BYTES);
  assign len_t = {2'b0, stage[CELL_WORDS-2][15:0]};
  assign lerr  = (len_t == '0) || (n_tot < len_t + 18'd8) ||
                 (n_tot - 18'd8 - len_t > 18'(CELL_BYTES - 1));
  assign rem_f = lerr ? 18'(CELL_BYTES - 8) + (h ? 18'(CELL_BYTES) : 18'd0)
                      : len_t + 18'(CELL_BYTES) + (h ? 18'(CELL_BYTES) : 18'd0) - n_tot;
  assign nw_f  = OK_W'((rem_f + 18'd3) >> 2);
  assign lb_f  = (rem_f[1:0] == 2'd0) ? 3'd4 : {1'b0, rem_f[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; wcnt <= '0; held_v <= '0; started <= '0;
      cvc <= '0; clast <= 1'b0; ccrc <= '0; ccnt <= '0;
      o_vc <= '0; o_h <= 1'b0; o_mode <= M_NORM; o_k <= '0; o_nw <= '0;
      o_lb <= 3'd4; o_st <= 2'd0; o_uu <= '0; o_cpi <= '0; o_crc <= '0; o_cnt <= '0;
    end else if (!busy) begin
      if (acc) begin
        if (wcnt == '0) begin
          cvc   <= in_data[4 +: VCID_W];
          clast <= in_data[1];
          ccrc  <= held_v[in_data[4 +: VCID_W]] ? crc_mem[in_data[4 +: VCID_W]] : '1;
          ccnt  <= held_v[in_data[4 +: VCID_W]] ? cnt_mem[in_data[4 +: VCID_W]] : '0;
          wcnt  <= WC_W'(1);
        end else begin
          ccrc <= crc_n;
          wcnt <= end_cell ? '0 : wcnt + 1'b1;
          if (end_cell) begin
            busy  <= 1'b1;
            o_vc  <= cvc;
            o_h   <= h;
            o_k   <= '0;
            o_crc <= crc_n;
            o_cnt <= n_tot[15:0];
            if (clast) begin
              o_mode <= M_LAST;
              o_nw   <= nw_f;
              o_lb   <= lb_f;
              o_st   <= lerr ? 2'd2 : (crc_n != RESIDUE) ? 2'd1 : 2'd0;
              o_uu   <= stage[CELL_WORDS-2][31:24];
              o_cpi  <= stage[CELL_WORDS-2][23:16];
            end else begin
              o_mode <= M_NORM;
              o_nw   <= h ? OK_W'(CELL_WORDS) : '0;
              o_lb   <= 3'd4;
              o_st   <= 2'd0;
            end
          end
        end
      end else if ((wcnt == '0) && (|exp_v)) begin
        busy   <= 1'b1;
        o_vc   <= exp_sel;
        o_h    <= 1'b1;
        o_k    <= '0;
        o_mode <= M_TMO;
        o_nw   <= OK_W'(CELL_WORDS);
        o_lb   <= 3'd4;
        o_st   <= 2'd3;
        o_uu   <= '0;
        o_cpi  <= '0;
      end
    end else if (fin) begin
      busy <= 1'b0;
      if (o_mode == M_NORM) begin
        held_v[o_vc]  <= 1'b1;
        started[o_vc] <= started[o_vc] | o_h;
      end else begin
        held_v[o_vc]  <= 1'b0;
        started[o_vc] <= 1'b0;
      end
    end else begin
      o_k <= o_k + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (acc && (wcnt != '0))
      stage[IX_W'(wcnt - 1'b1)] <= in_data;
    if (fin && (o_mode == M_NORM)) begin
      for (int w = 0; w < CELL_WORDS; w++)
        held[o_vc][w] <= stage[w];
      crc_mem[o_vc] <= o_crc;
      cnt_mem[o_vc] <= o_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < NUM_VC; v++) tmr[v] <= '0;
    end else begin
      for (int v = 0; v < NUM_VC; v++) begin
        if (end_cell && (cvc == VCID_W'(v)))
          tmr[v] <= '0;
        else if (fin && (o_mode == M_TMO) && (o_vc == VCID_W'(v)))
          tmr[v] <= '0;
        else if (tick && held_v[v] && (tmr[v] != TMR_W'(TMO_TICKS)))
          tmr[v] <= tmr[v] + 1'b1;
      end
    end
  end

  assign use_held   = o_h && (o_k < OK_W'(CELL_WORDS));
  assign rd_ix      = IX_W'(use_held ? o_k : (o_k - (o_h ? OK_W'(CELL_WORDS) : '0)));
  assign out_valid  = busy && (o_k < o_nw);
  assign out_data   = use_held ? held[o_vc][rd_ix] : stage[rd_ix];
  assign out_vcid   = o_vc;
  assign out_sop    = out_valid && (o_k == '0) && !started[o_vc];
  assign out_eop    = out_valid && (o_mode != M_NORM) && (o_k == o_nw - 1'b1);
  assign out_bytes  = out_eop ? o_lb : 3'd4;
  assign out_status = out_eop ? o_st : 2'd0;
  assign out_uu     = out_eop ? o_uu : 8'd0;
  assign out_cpi    = out_eop ? o_cpi : 8'd0;
endmodule

// File: rtl/aal5_reasm_chk.sv
`timescale 1ns/1ps
module aal5_reasm_chk #(
  parameter int NUM_VC = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_ready,
  input logic                      out_valid,
  input logic [$clog2(NUM_VC)-1:0] out_vcid,
  input logic                      out_sop,
  input logic                      out_eop,
  input logic [2:0]                out_bytes,
  input logic [1:0]                out_status
);
  p_input_stalled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  p_sop_in_burst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> out_valid);
  p_gap_after_eop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |=> !out_valid);
  p_vcid_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eop) |=> (!out_valid || $stable(out_vcid)));
  p_bytes_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |-> (out_bytes >= 3'd1 && out_bytes <= 3'd4));
  p_timeout_whole_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_eop && out_status == 2'd3) |-> out_bytes == 3'd4);
endmodule

bind aal5_reasm aal5_reasm_chk #(.NUM_VC(NUM_VC)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_vcid(out_vcid), .out_sop(out_sop), .out_eop(out_eop),
  .out_bytes(out_bytes), .out_status(out_status)
);

// File: tb/tb_aal5_reasm.sv
`timescale 1ns/1ps
module tb_aal5_reasm;
  localparam int NVC = 4;
  localparam int TMO = 8;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, tick = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, out_sop, out_eop;
  logic [31:0] out_data;
  logic [1:0] out_vcid;
  logic [2:0] out_bytes;
  logic [1:0] out_status;
  logic [7:0] out_uu, out_cpi;

  aal5_reasm #(.NUM_VC(NVC), .TMO_TICKS(TMO), .CELL_WORDS(12)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .tick(tick), .out_valid(out_valid), .out_data(out_data),
    .out_vcid(out_vcid), .out_sop(out_sop), .out_eop(out_eop), .out_bytes(out_bytes),
    .out_status(out_status), .out_uu(out_uu), .out_cpi(out_cpi));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int rxn[NVC], sopc[NVC], eopc[NVC], lst[NVC], luu[NVC], lcpi[NVC];
  logic [7:0] rxb[NVC][256];
  logic [7:0] txb[2][1024];
  int txc[2];
  int nb;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      nb = out_eop ? int'(out_bytes) : 4;
      for (int b = 0; b < nb; b++) begin
        if (rxn[out_vcid] < 256) rxb[out_vcid][rxn[out_vcid]] = out_data[31-8*b -: 8];
        rxn[out_vcid]++;
      end
      if (out_sop) sopc[out_vcid]++;
      if (out_eop) begin
        eopc[out_vcid]++;
        lst[out_vcid]  = int'(out_status);
        luu[out_vcid]  = int'(out_uu);
        lcpi[out_vcid] = int'(out_cpi);
      end
    end
  end

  function automatic logic [31:0] crc_b(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 7; i >= 0; i--)
      r = {r[30:0], 1'b0} ^ ((r[31] ^ b[i]) ? 32'h04C11DB7 : 32'h0);
    return r;
  endfunction

  task automatic clear_rx();
    for (int v = 0; v < NVC; v++) begin
      rxn[v] = 0; sopc[v] = 0; eopc[v] = 0; lst[v] = -1; luu[v] = -1; lcpi[v] = -1;
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic build_pkt(input int s, input int len, input int lenf, input bit badcrc,
                           input logic [7:0] uu, input logic [7:0] cpi, input logic [7:0] seed);
    int nc, tot;
    logic [31:0] c;
    nc = (len + 8 + 47) / 48;
    tot = nc * 48;
    for (int i = 0; i < tot; i++) txb[s][i] = (i < len) ? 8'(int'(seed) + i * 13) : 8'h00;
    txb[s][tot-8] = uu;
    txb[s][tot-7] = cpi;
    txb[s][tot-6] = 8'(lenf >> 8);
    txb[s][tot-5] = 8'(lenf);
    c = 32'hFFFFFFFF;
    for (int i = 0; i < tot - 4; i++) c = crc_b(c, txb[s][i]);
    c = ~c;
    for (int k = 0; k < 4; k++) txb[s][tot-4+k] = c[31-8*k -: 8];
    if (badcrc) txb[s][0] = txb[s][0] ^ 8'h01;
    txc[s] = nc;
  endtask

  task automatic put(input logic [31:0] w);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_cell(input int s, input int ci, input logic [15:0] vci, input logic [7:0] vpi);
    int base;
    bit last;
    last = (ci == txc[s] - 1);
    base = ci * 48;
    put({4'h0, vpi, vci, 2'b00, last, 1'b0});
    for (int w = 0; w < 12; w++)
      put({txb[s][base+4*w], txb[s][base+4*w+1], txb[s][base+4*w+2], txb[s][base+4*w+3]});
  endtask

  task automatic send_pkt(input int s, input logic [15:0] vci, input logic [7:0] vpi);
    for (int ci = 0; ci < txc[s]; ci++) send_cell(s, ci, vci, vpi);
    wait_cyc(40);
  endtask

  task automatic pulse_tick(input int n);
    repeat (n) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic check_pkt(input int v, input int s, input int nbytes, input int st,
                           input int uu, input int cpi, input string tag);
    int errs;
    errs = 0;
    chk(rxn[v] == nbytes, {tag, " byte count"}, rxn[v], nbytes);
    for (int i = 0; i < nbytes && i < rxn[v] && i < 256; i++)
      if (rxb[v][i] !== txb[s][i]) errs++;
    chk(errs == 0, {tag, " data mismatches"}, errs, 0);
    chk(lst[v] == st, {tag, " status"}, lst[v], st);
    if (st != 3) begin
      chk(luu[v] == uu, {tag, " uu"}, luu[v], uu);
      chk(lcpi[v] == cpi, {tag, " cpi"}, lcpi[v], cpi);
    end
    chk(sopc[v] == 1, {tag, " R4 sop count"}, sopc[v], 1);
    chk(eopc[v] == 1, {tag, " R4 eop count"}, eopc[v], 1);
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R12 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R12 in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_single();
    clear_rx();
    build_pkt(0, 20, 20, 1'b0, 8'h3C, 8'h00, 8'h11);
    send_pkt(0, 16'hFF00, 8'h5A);
    check_pkt(0, 0, 20, 0, 'h3C, 0, "R1 R5 R8 single cell on vc0");
  endtask

  task automatic t_boundary();
    clear_rx();
    build_pkt(0, 40, 40, 1'b0, 8'h01, 8'h02, 8'h21);
    send_pkt(0, 16'h0002, 8'h00);
    check_pkt(2, 0, 40, 0, 'h01, 'h02, "R7 length slack 0");
    clear_rx();
    build_pkt(0, 41, 41, 1'b0, 8'h03, 8'h04, 8'h31);
    send_pkt(0, 16'h0002, 8'h00);
    check_pkt(2, 0, 41, 0, 'h03, 'h04, "R7 length slack 47");
    clear_rx();
    build_pkt(0, 44, 44, 1'b0, 8'h05, 8'h06, 8'h41);
    send_pkt(0, 16'h0003, 8'h00);
    check_pkt(3, 0, 44, 0, 'h05, 'h06, "R5 pad fills final cell");
  endtask

  task automatic t_holdback();
    clear_rx();
    build_pkt(0, 100, 100, 1'b0, 8'h77, 8'h00, 8'h51);
    send_cell(0, 0, 16'h7FF5, 8'h00);
    wait_cyc(30);
    chk(rxn[1] == 0, "R3 first cell held", rxn[1], 0);
    send_cell(0, 1, 16'h7FF5, 8'h00);
    wait_cyc(30);
    chk(rxn[1] == 48, "R3 second cell releases first", rxn[1], 48);
    chk(eopc[1] == 0, "R3 no end yet", eopc[1], 0);
    send_cell(0, 2, 16'h7FF5, 8'h00);
    wait_cyc(40);
    check_pkt(1, 0, 100, 0, 'h77, 0, "R3 three-cell packet");
  endtask

  task automatic t_crc();
    clear_rx();
    build_pkt(0, 60, 60, 1'b1, 8'h10, 8'h00, 8'h61);
    send_pkt(0, 16'h0006, 8'h00);
    check_pkt(2, 0, 60, 1, 'h10, 0, "R6 corrupted byte");
  endtask

  task automatic t_len();
    clear_rx();
    build_pkt(0, 30, 200, 1'b0, 8'h20, 8'h00, 8'h71);
    send_pkt(0, 16'h0000, 8'h00);
    check_pkt(0, 0, 40, 2, 'h20, 0, "R7 length too large");
    clear_rx();
    build_pkt(0, 30, 0, 1'b0, 8'h21, 8'h00, 8'h72);
    send_pkt(0, 16'h0000, 8'h00);
    check_pkt(0, 0, 40, 2, 'h21, 0, "R7 zero length");
    clear_rx();
    build_pkt(0, 60, 10, 1'b0, 8'h22, 8'h00, 8'h73);
    send_pkt(0, 16'h0000, 8'h00);
    check_pkt(0, 0, 88, 2, 'h22, 0, "R7 length too small two cells");
  endtask

  task automatic t_interleave();
    clear_rx();
    build_pkt(0, 90, 90, 1'b0, 8'hA0, 8'h00, 8'h81);
    build_pkt(1, 130, 130, 1'b0, 8'hB0, 8'h00, 8'h91);
    send_cell(0, 0, 16'h0000, 8'h00);
    send_cell(1, 0, 16'h0001, 8'h00);
    send_cell(0, 1, 16'h0000, 8'h00);
    send_cell(1, 1, 16'h0001, 8'h00);
    send_cell(1, 2, 16'h0001, 8'h00);
    send_cell(0, 2, 16'h0000, 8'h00);
    wait_cyc(40);
    check_pkt(0, 0, 90, 0, 'hA0, 0, "R11 interleaved vc0");
    check_pkt(1, 1, 130, 0, 'hB0, 0, "R11 interleaved vc1");
  endtask

  task automatic t_timeout();
    clear_rx();
    build_pkt(0, 150, 150, 1'b0, 8'h00, 8'h00, 8'hC1);
    send_cell(0, 0, 16'h0002, 8'h00);
    wait_cyc(4);
    pulse_tick(TMO - 1);
    wait_cyc(30);
    chk(rxn[2] == 0, "R9 no output one tick short", rxn[2], 0);
    pulse_tick(1);
    wait_cyc(30);
    check_pkt(2, 0, 48, 3, 0, 0, "R9 timeout closes");
  endtask

  task automatic t_restart();
    clear_rx();
    build_pkt(0, 150, 150, 1'b0, 8'h44, 8'h55, 8'hD1);
    send_cell(0, 0, 16'h0003, 8'h00);
    wait_cyc(4);
    pulse_tick(TMO - 1);
    send_cell(0, 1, 16'h0003, 8'h00);
    wait_cyc(4);
    pulse_tick(TMO - 1);
    wait_cyc(30);
    chk(rxn[3] == 48, "R10 timer restarted, only released cell seen", rxn[3], 48);
    chk(eopc[3] == 0, "R10 no timeout end", eopc[3], 0);
    send_cell(0, 2, 16'h0003, 8'h00);
    send_cell(0, 3, 16'h0003, 8'h00);
    wait_cyc(40);
    check_pkt(3, 0, 150, 0, 'h44, 'h55, "R10 packet completes");
  endtask

  bit finished = 1'b0;

  initial begin
    clear_rx();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_boundary();
    t_holdback();
    t_crc();
    t_len();
    t_interleave();
    t_timeout();
    t_restart();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #750000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule